// File: doc/BRIEF.md
# Four-Child Result Reduction Node

This block is one node of a reduction tree that gathers search results from a bank of memory arrays. Four children each deliver a partial result: a signed partial sum, an unsigned match count, a row index of the first match inside that child, a flag saying whether the child matched at all, and a flag saying that the child's own arithmetic hit a divide-by-zero. The node combines the four into one result for its parent.

The three reductions run side by side:
- the signed partial sums are added;
- the match counts are added;
- the first-match index is taken from the lowest-numbered child that matched, with the child number placed above that child's local index.

The node is a two-stage pipeline and accepts a new input set on every cycle. A valid flag travels with the data. Two sticky flags report faults upward. One is a sum overflow. The other is a divide-by-zero reported by any child, which also aborts the summation for that set. A single clear input resets both flags.

Top module: `quad_reduce_node`

## Requirements
- R1: `res_valid` is high exactly two clock cycles after an edge at which `in_valid` was sampled high, and input sets may arrive on consecutive cycles.
- R2: For a valid set with no divide-by-zero, `res_sum` equals the sum of the four signed `ch_sum` fields, wrapped to SUM_W bits in two's complement.
- R3: `ovf_flag` rises with the result of a valid set whose exact sum lies outside the signed SUM_W range. Once set, it stays high until cleared. Sets that are invalid, or that carry a divide-by-zero, do not raise it.
- R4: When `flag_clr` is high at the clock edge that registers a result, both sticky flags drop, unless that same result sets one of them again. Setting wins over clearing.
- R5: `res_cnt` (CNT_W+2 bits) equals the unsigned sum of the four `ch_cnt` fields.
- R6: `res_hit` is high when any child's `ch_hit` bit is high. `res_idx` is then the 2-bit number of the lowest-numbered child with `ch_hit` high, in the upper two bits, followed by that child's IDX_W-bit `ch_idx`. Child k occupies bits `[k*W +: W]` of each packed input.
- R7: When no child's `ch_hit` bit is high, `res_hit` is low and `res_idx` is zero.
- R8: When any `ch_dz` bit of a valid set is high, that set's `res_sum` is zero, `res_abort` is high with it, and `dz_flag` becomes high and sticky. The count and index are still reported.
- R9: While reset is high, and after it, until a valid result arrives, all outputs are zero. When `res_valid` is low, every data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The four child fields form a valid set |
| ch_sum | input | 4*SUM_W | Signed partial sums, child k at [k*SUM_W +: SUM_W] |
| ch_cnt | input | 4*CNT_W | Unsigned match counts |
| ch_idx | input | 4*IDX_W | First-match row index inside each child |
| ch_hit | input | 4 | Child has at least one match |
| ch_dz | input | 4 | Child reports a divide-by-zero |
| flag_clr | input | 1 | Clears both sticky flags |
| res_valid | output | 1 | Result valid |
| res_sum | output | SUM_W | Total signed sum |
| res_cnt | output | CNT_W+2 | Total match count |
| res_idx | output | IDX_W+2 | Global first-match index |
| res_hit | output | 1 | Some child matched |
| res_abort | output | 1 | Summation of this set was aborted |
| ovf_flag | output | 1 | Sticky sum overflow |
| dz_flag | output | 1 | Sticky divide-by-zero |

## Verification
The hardest case to reach is a clear that lands on the same edge as a result that sets a flag again. Near it is a set with both a divide-by-zero and an out-of-range sum, where the abort must suppress the overflow. Directed sequences place `flag_clr` one cycle after a set with a large positive or large negative sum, and also after a set with a zero sum. This covers clears with and without a competing event. Back-to-back sets with only a high-numbered child matching, or with no child matching, cover the first-match paths at full throughput.

// File: rtl/quad_reduce_pkg.sv
package quad_reduce_pkg;
    localparam int unsigned CHILDREN = 4;
    localparam int unsigned SEL_W    = $clog2(CHILDREN);
endpackage

// File: rtl/pair_merge.sv
module pair_merge #(
    parameter int unsigned SUM_W = 16,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned BASE  = 0
) (
    input  logic signed [SUM_W-1:0] a_sum,
    input  logic signed [SUM_W-1:0] b_sum,
    input  logic [CNT_W-1:0]        a_cnt,
    input  logic [CNT_W-1:0]        b_cnt,
    input  logic [IDX_W-1:0]        a_idx,
    input  logic [IDX_W-1:0]        b_idx,
    input  logic                    a_hit,
    input  logic                    b_hit,
    input  logic                    a_dz,
    input  logic                    b_dz,
    output logic signed [SUM_W:0]   p_sum,
    output logic [CNT_W:0]          p_cnt,
    output logic [IDX_W+quad_reduce_pkg::SEL_W-1:0] p_idx,
    output logic                    p_hit,
    output logic                    p_dz
);
    import quad_reduce_pkg::*;
    localparam logic [SEL_W-1:0] SEL_A = SEL_W'(BASE);
    localparam logic [SEL_W-1:0] SEL_B = SEL_W'(BASE + 1);

    always_comb begin
        p_sum = SUM_W'(0);
        p_sum = (SUM_W+1)'(a_sum) + (SUM_W+1)'(b_sum);
        p_cnt = (CNT_W+1)'(a_cnt) + (CNT_W+1)'(b_cnt);
        p_hit = a_hit | b_hit;
        p_dz  = a_dz | b_dz;
        if (a_hit)      p_idx = {SEL_A, a_idx};
        else if (b_hit) p_idx = {SEL_B, b_idx};
        else            p_idx = '0;
    end
endmodule

// File: rtl/root_merge.sv
module root_merge #(
    parameter int unsigned SUM_W = 16,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned XW    = 8
) (
    input  logic signed [SUM_W:0] lo_sum,
    input  logic signed [SUM_W:0] hi_sum,
    input  logic [CNT_W:0]        lo_cnt,
    input  logic [CNT_W:0]        hi_cnt,
    input  logic [XW-1:0]         lo_idx,
    input  logic [XW-1:0]         hi_idx,
    input  logic                  lo_hit,
    input  logic                  hi_hit,
    input  logic                  any_dz,
    output logic [SUM_W-1:0]      t_sum,
    output logic [CNT_W+1:0]      t_cnt,
    output logic [XW-1:0]         t_idx,
    output logic                  t_hit,
    output logic                  t_ovf
);
    logic signed [SUM_W+1:0] full;
    logic [2:0]              top3;

    always_comb begin
        full  = (SUM_W+2)'(lo_sum) + (SUM_W+2)'(hi_sum);
        top3  = full[SUM_W+1:SUM_W-1];
        t_ovf = !any_dz && !((top3 == 3'b000) || (top3 == 3'b111));
        t_sum = any_dz ? '0 : full[SUM_W-1:0];
        t_cnt = (CNT_W+2)'(lo_cnt) + (CNT_W+2)'(hi_cnt);
        t_hit = lo_hit | hi_hit;
        t_idx = lo_hit ? lo_idx : (hi_hit ? hi_idx : '0);
    end
endmodule

// File: rtl/quad_reduce_node.sv
module quad_reduce_node #(
    parameter int unsigned SUM_W = 16,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [4*SUM_W-1:0]   ch_sum,
    input  logic [4*CNT_W-1:0]   ch_cnt,
    input  logic [4*IDX_W-1:0]   ch_idx,
    input  logic [3:0]           ch_hit,
    input  logic [3:0]           ch_dz,
    input  logic                 flag_clr,
    output logic                 res_valid,
    output logic [SUM_W-1:0]     res_sum,
    output logic [CNT_W+1:0]     res_cnt,
    output logic [IDX_W+1:0]     res_idx,
    output logic                 res_hit,
    output logic                 res_abort,
    output logic                 ovf_flag,
    output logic                 dz_flag
);
    import quad_reduce_pkg::*;
    localparam int unsigned XW    = IDX_W + SEL_W;
    localparam int unsigned PAIRS = CHILDREN / 2;

    typedef struct packed {
        logic                v;
        logic [SUM_W:0]      sum_lo;
        logic [SUM_W:0]      sum_hi;
        logic [CNT_W:0]      cnt_lo;
        logic [CNT_W:0]      cnt_hi;
        logic [XW-1:0]       idx_lo;
        logic [XW-1:0]       idx_hi;
        logic                hit_lo;
        logic                hit_hi;
        logic                dz;
    } stage1_t;

    typedef struct packed {
        logic                v;
        logic [SUM_W-1:0]    sum;
        logic [CNT_W+1:0]    cnt;
        logic [XW-1:0]       idx;
        logic                hit;
        logic                abort;
        logic                ovf;
        logic                dzf;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic [SUM_W:0] p_sum [PAIRS];
    logic [CNT_W:0] p_cnt [PAIRS];
    logic [XW-1:0]  p_idx [PAIRS];
    logic           p_hit [PAIRS];
    logic           p_dz  [PAIRS];

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        pair_merge #(
            .SUM_W(SUM_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .BASE(2*g)
        ) u_pair (
            .a_sum (ch_sum[(2*g)*SUM_W +: SUM_W]),
            .b_sum (ch_sum[(2*g+1)*SUM_W +: SUM_W]),
            .a_cnt (ch_cnt[(2*g)*CNT_W +: CNT_W]),
            .b_cnt (ch_cnt[(2*g+1)*CNT_W +: CNT_W]),
            .a_idx (ch_idx[(2*g)*IDX_W +: IDX_W]),
            .b_idx (ch_idx[(2*g+1)*IDX_W +: IDX_W]),
            .a_hit (ch_hit[2*g]),
            .b_hit (ch_hit[2*g+1]),
            .a_dz  (ch_dz[2*g]),
            .b_dz  (ch_dz[2*g+1]),
            .p_sum (p_sum[g]),
            .p_cnt (p_cnt[g]),
            .p_idx (p_idx[g]),
            .p_hit (p_hit[g]),
            .p_dz  (p_dz[g])
        );
    end

    logic [SUM_W-1:0] t_sum;
    logic [CNT_W+1:0] t_cnt;
    logic [XW-1:0]    t_idx;
    logic             t_hit;
    logic             t_ovf;

    root_merge #(.SUM_W(SUM_W), .CNT_W(CNT_W), .XW(XW)) u_root (
        .lo_sum (s1_q.sum_lo),
        .hi_sum (s1_q.sum_hi),
        .lo_cnt (s1_q.cnt_lo),
        .hi_cnt (s1_q.cnt_hi),
        .lo_idx (s1_q.idx_lo),
        .hi_idx (s1_q.idx_hi),
        .lo_hit (s1_q.hit_lo),
        .hi_hit (s1_q.hit_hi),
        .any_dz (s1_q.dz),
        .t_sum  (t_sum),
        .t_cnt  (t_cnt),
        .t_idx  (t_idx),
        .t_hit  (t_hit),
        .t_ovf  (t_ovf)
    );

    always_comb begin
        s1_d = '0;
        if (in_valid) begin
            s1_d.v      = 1'b1;
            s1_d.sum_lo = p_sum[0];
            s1_d.sum_hi = p_sum[1];
            s1_d.cnt_lo = p_cnt[0];
            s1_d.cnt_hi = p_cnt[1];
            s1_d.idx_lo = p_idx[0];
            s1_d.idx_hi = p_idx[1];
            s1_d.hit_lo = p_hit[0];
            s1_d.hit_hi = p_hit[1];
            s1_d.dz     = p_dz[0] | p_dz[1];
        end

        s2_d       = '0;
        s2_d.ovf   = s2_q.ovf & ~flag_clr;
        s2_d.dzf   = s2_q.dzf & ~flag_clr;
        if (s1_q.v) begin
            s2_d.v     = 1'b1;
            s2_d.sum   = t_sum;
            s2_d.cnt   = t_cnt;
            s2_d.idx   = t_idx;
            s2_d.hit   = t_hit;
            s2_d.abort = s1_q.dz;
            s2_d.ovf   = s2_d.ovf | t_ovf;
            s2_d.dzf   = s2_d.dzf | s1_q.dz;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign res_valid = s2_q.v;
    assign res_sum   = s2_q.sum;
    assign res_cnt   = s2_q.cnt;
    assign res_idx   = s2_q.idx;
    assign res_hit   = s2_q.hit;
    assign res_abort = s2_q.abort;
    assign ovf_flag  = s2_q.ovf;
    assign dz_flag   = s2_q.dzf;
endmodule

// File: rtl/quad_reduce_node_chk.sv
module quad_reduce_node_chk #(
    parameter int unsigned SUM_W = 16,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             flag_clr,
    input logic             res_valid,
    input logic [SUM_W-1:0] res_sum,
    input logic [IDX_W+1:0] res_idx,
    input logic             res_hit,
    input logic             res_abort,
    input logic             ovf_flag,
    input logic             dz_flag
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 res_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !res_valid);
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);
    a_r4_clear_ovf: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !res_valid) |=> (!ovf_flag || res_valid));
    a_r7_no_hit_zero: assert property (@(posedge clk) disable iff (rst)
        !res_hit |-> (res_idx == '0));
    a_r8_abort_zero: assert property (@(posedge clk) disable iff (rst)
        res_abort |-> (res_sum == '0 && dz_flag));
    a_r8_dz_sticky: assert property (@(posedge clk) disable iff (rst)
        (dz_flag && !flag_clr) |=> dz_flag);
    a_r9_gated: assert property (@(posedge clk) disable iff (rst)
        (res_hit || res_abort) |-> res_valid);
endmodule

bind quad_reduce_node quad_reduce_node_chk #(
    .SUM_W(SUM_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .flag_clr(flag_clr),
    .res_valid(res_valid), .res_sum(res_sum), .res_idx(res_idx),
    .res_hit(res_hit), .res_abort(res_abort),
    .ovf_flag(ovf_flag), .dz_flag(dz_flag)
);

// File: tb/quad_reduce_node_bench.sv
module quad_reduce_node_bench;
    localparam int SW = 16;
    localparam int CW = 8;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              in_valid = 1'b0;
    logic [4*SW-1:0]   ch_sum = '0;
    logic [4*CW-1:0]   ch_cnt = '0;
    logic [4*IW-1:0]   ch_idx = '0;
    logic [3:0]        ch_hit = '0;
    logic [3:0]        ch_dz  = '0;
    logic              flag_clr = 1'b0;
    logic              res_valid, res_hit, res_abort, ovf_flag, dz_flag;
    logic [SW-1:0]     res_sum;
    logic [CW+1:0]     res_cnt;
    logic [IW+1:0]     res_idx;

    quad_reduce_node #(.SUM_W(SW), .CNT_W(CW), .IDX_W(IW)) u_quad_reduce_node (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ch_sum(ch_sum),
        .ch_cnt(ch_cnt), .ch_idx(ch_idx), .ch_hit(ch_hit), .ch_dz(ch_dz),
        .flag_clr(flag_clr), .res_valid(res_valid), .res_sum(res_sum),
        .res_cnt(res_cnt), .res_idx(res_idx), .res_hit(res_hit),
        .res_abort(res_abort), .ovf_flag(ovf_flag), .dz_flag(dz_flag)
    );

    typedef struct packed {
        logic            v;
        logic [4*SW-1:0] s;
        logic [4*CW-1:0] c;
        logic [4*IW-1:0] x;
        logic [3:0]      h;
        logic [3:0]      z;
        logic            clr;
    } set_t;

    set_t nxt, p1, p2;
    int   n_run = 0;
    int   n_fail = 0;
    bit   m_ovf = 0, m_dz = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare();
        longint tot;
        int     cnt;
        bit     anyz, hit, ev_ovf;
        logic [IW+1:0] idx;
        logic [SW-1:0] esum;
        tot = 0; cnt = 0; anyz = 0; hit = 0; idx = '0;
        for (int k = 0; k < 4; k++) begin
            tot += longint'($signed(p2.s[k*SW +: SW]));
            cnt += int'(p2.c[k*CW +: CW]);
            anyz |= p2.z[k];
            if (!hit && p2.h[k]) begin
                hit = 1;
                idx = {2'(k), p2.x[k*IW +: IW]};
            end
        end
        ev_ovf = !anyz && (tot > longint'(2**(SW-1)-1) || tot < -longint'(2**(SW-1)));
        esum = anyz ? '0 : tot[SW-1:0];
        check(res_valid == p2.v, "R1 valid", res_valid, p2.v);
        if (p2.v) begin
            check(res_sum == esum, anyz ? "R8 sum" : "R2 sum", res_sum, esum);
            check(res_cnt == (CW+2)'(cnt), "R5 count", res_cnt, cnt);
            check(res_hit == hit && res_idx == idx, hit ? "R6 index" : "R7 index",
                  {res_hit, res_idx}, {hit, idx});
            check(res_abort == anyz, "R8 abort", res_abort, anyz);
            m_ovf = ev_ovf | (m_ovf & ~p1.clr);
            m_dz  = anyz   | (m_dz  & ~p1.clr);
        end else begin
            check({res_sum, res_cnt, res_idx, res_hit, res_abort} == '0, "R9 idle zero",
                  {res_sum, res_cnt, res_idx}, 0);
            m_ovf = m_ovf & ~p1.clr;
            m_dz  = m_dz  & ~p1.clr;
        end
        check(ovf_flag == m_ovf, "R3 R4 ovf_flag", ovf_flag, m_ovf);
        check(dz_flag == m_dz, "R4 R8 dz_flag", dz_flag, m_dz);
    endtask

    task automatic tick();
        @(negedge clk);
        if (!rst) compare();
        p2 = p1;
        p1 = nxt;
        in_valid = nxt.v; ch_sum = nxt.s; ch_cnt = nxt.c; ch_idx = nxt.x;
        ch_hit = nxt.h; ch_dz = nxt.z; flag_clr = nxt.clr;
        nxt = '0;
    endtask

    task automatic put_sums(input int a, input int b, input int c, input int d);
        nxt.v = 1;
        nxt.s = {SW'(d), SW'(c), SW'(b), SW'(a)};
    endtask

    initial begin
        nxt = '0; p1 = '0; p2 = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check({res_valid, res_sum, res_cnt, res_idx, res_hit, res_abort, ovf_flag, dz_flag} == '0,
              "R9 reset", res_sum, 0);
        rst = 1'b0;
        tick(); tick();

        // R2 R5 R6: plain set, child 1 first match
        put_sums(100, -40, 7, 3);
        nxt.c = {8'd4, 8'd0, 8'd9, 8'd0}; nxt.h = 4'b1010;
        nxt.x = {6'd11, 6'd0, 6'd33, 6'd0};
        tick();
        // R6: only child 3 matches, back to back
        put_sums(-5, -6, -7, -8); nxt.h = 4'b1000; nxt.x = {6'd63, 18'h3ffff};
        nxt.c = {8'd255, 8'd255, 8'd255, 8'd255};
        tick();
        // R7: no hit
        put_sums(1, 2, 3, 4); nxt.x = '1;
        tick();
        // R3: positive overflow
        put_sums(32767, 32767, 1, 0); nxt.h = 4'b0001;
        tick();
        tick();
        tick();
        // R4: clear with no competing event
        nxt.clr = 1; tick();
        tick(); tick();
        // R3: negative overflow, then clear on the edge that re-sets it
        put_sums(-32768, -32768, 0, 0); tick();
        put_sums(-32768, -1, 0, 0); nxt.clr = 1; tick();
        tick(); tick();
        // R8: divide-by-zero with an out-of-range sum
        put_sums(32767, 32767, 32767, 32767); nxt.z = 4'b0100; nxt.h = 4'b0110;
        nxt.x = {6'd0, 6'd21, 6'd17, 6'd0}; nxt.c = {8'd1, 8'd2, 8'd3, 8'd4};
        tick();
        put_sums(10, 20, 30, 40); tick();
        tick(); tick();
        nxt.clr = 1; tick();
        tick(); tick();
        // exact boundaries: no overflow at the range limits
        put_sums(32767, 0, 0, 0); tick();
        put_sums(-32768, 0, 0, 0); tick();
        put_sums(16384, 16383, 0, 0); tick();
        // mixed stream with gaps
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 3) != 0) begin
                nxt.v = 1;
                nxt.s = {$urandom(), $urandom()};
                if ($urandom_range(0, 1) == 1) nxt.s = nxt.s >> ($urandom_range(0, 12));
                nxt.c = $urandom();
                nxt.x = $urandom();
                nxt.h = 4'($urandom());
                nxt.z = ($urandom_range(0, 9) == 0) ? 4'($urandom()) : 4'b0;
            end
            nxt.clr = ($urandom_range(0, 7) == 0);
            tick();
        end
        tick(); tick(); tick();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule